// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 64 numbered request lines, qualifies each one with its own sense mode, enable and priority level, and drives a single interrupt line to the processor. A small register bus reaches one control word per source, a global mask word and a status word. Software raises the mask to open the controller, takes the interrupt, and reads the status word to find which source won.

Each input is first resynchronized. It is then sensed as a falling edge, a rising edge, a low level or a high level. Edge requests are held until software clears them. Level requests simply track the input. Among the enabled, pending sources whose level is numerically below the mask, the lowest level wins, and the lowest source number breaks ties. An acknowledge from the processor saves the old mask in the status word, records the winner and lifts the mask to the winner's level. Sources of equal or weaker priority then stay out until software restores the mask. Source number n is input bit n. External pins are expected on numbers 1 to 8 and inter-processor requests on 56 to 63.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq` is 0, the mask word reads 0, the status word reads only its vector tag, and every control word reads 0x07: level 7, sense 00, disabled, nothing pending.
- R2: Each input passes two synchronizing flops. A level-sensed change shows in the pending bit and on `cpu_irq` after the second rising clock edge, not after the first.
- R3: The control word at address 0x80+n holds the level in bits [2:0], the sense mode in bits [4:3], enable in bit 6 and pending in bit 7. The sense codes are 00 falling edge, 01 low level, 10 rising edge and 11 high level.
- R4: An edge-mode pending bit stays set after the input returns. A control write with bit 7 cleared clears it. A write with bit 7 set leaves it as it is.
- R5: A level-mode pending bit follows the synchronized input, so `cpu_irq` falls once the input goes inactive.
- R6: A source whose enable bit is 0, or whose level is 7, never raises `cpu_irq`.
- R7: The mask word at address 0x01, bits [2:0], admits only sources whose level is less than its value. A mask of 0 blocks every source.
- R8: Among admitted sources the lowest level wins. On a tie the lowest source number wins.
- R9: When `cpu_ack` is high while `cpu_irq` is high, the status word records the winner number and the mask value from before the acknowledge, and the mask becomes the winner's level. An acknowledge with `cpu_irq` low changes nothing.
- R10: The status word at address 0x00 carries the source number in bits [5:0], the saved mask in bits [10:8] and the parameter `VEC_TAG` in bits [31:28]. All other bits read 0.
- R11: `cpu_irq` drops in the cycle right after a write that clears the pending bit or lowers the mask below the pending level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Raw request lines, bit n is source n |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_ack | input | 1 | Processor acknowledge |
| cpu_irq | output | 1 | Interrupt to the processor |

## Verification
The assertions check on every cycle that a zero mask or a fully disabled set of sources keeps `cpu_irq` low. They also check that every taken acknowledge saves the prior mask and leaves a strictly tighter one. The bench scenarios cover what needs a specific history. That includes the two-cycle synchronizer latency, the four sense polarities, edge latching against set-and-clear writes, the tie break by source number and the exact status word after a sequence of nested acknowledges.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 64,
  parameter logic [3:0] VEC_TAG = 4'hA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            cpu_ack,
  output logic            cpu_irq
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [2:0] LV_OFF = 3'd7;
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_MASK = 8'h01;

  logic [NSRC-1:0] s1, s2, s3, en, epend, pend, acc;
  logic [NSRC-1:0][2:0] lvl;
  logic [NSRC-1:0][1:0] sns;
  logic [2:0] mask, st_mask, best_lvl;
  logic [IW-1:0] st_src, best_id;
  logic found;
  logic unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:8], bus_wdata[5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= src_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      pend[i] = sns[i][0] ? (s2[i] == sns[i][1]) : epend[i];
      acc[i]  = en[i] && pend[i] && (lvl[i] != LV_OFF) && (lvl[i] < mask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl   <= {NSRC{LV_OFF}};
      sns   <= '0;
      en    <= '0;
      epend <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        logic hit, wsel;
        hit  = sns[i][1] ? (s2[i] && !s3[i]) : (!s2[i] && s3[i]);
        wsel = bus_wr && (bus_addr == 8'(128 + i));
        if (wsel) begin
          lvl[i] <= bus_wdata[2:0];
          sns[i] <= bus_wdata[4:3];
          en[i]  <= bus_wdata[6];
        end
        if (!sns[i][0] && hit) epend[i] <= 1'b1;
        else if (wsel && !bus_wdata[7]) epend[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    found    = 1'b0;
    best_lvl = LV_OFF;
    best_id  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (acc[i] && (!found || lvl[i] < best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl[i];
        best_id  = IW'(i);
      end
    end
  end

  assign cpu_irq = found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask    <= '0;
      st_mask <= '0;
      st_src  <= '0;
    end else if (cpu_ack && found) begin
      st_src  <= best_id;
      st_mask <= mask;
      mask    <= best_lvl;
    end else if (bus_wr && bus_addr == A_MASK) begin
      mask <= bus_wdata[2:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT) begin
      bus_rdata[31:28]  = VEC_TAG;
      bus_rdata[10:8]   = st_mask;
      bus_rdata[IW-1:0] = st_src;
    end else if (bus_addr == A_MASK) begin
      bus_rdata[2:0] = mask;
    end else begin
      for (int i = 0; i < NSRC; i++)
        if (bus_addr == 8'(128 + i))
          bus_rdata[7:0] = {pend[i], en[i], 1'b0, sns[i], lvl[i]};
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_irq,
  input logic            cpu_ack,
  input logic [2:0]      mask,
  input logic [2:0]      st_mask,
  input logic [NSRC-1:0] en
);
  // R7
  mask_zero_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'd0) |-> !cpu_irq);

  // R6
  all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !cpu_irq);

  // R9
  ack_save_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq) |=> (st_mask == $past(mask)));

  // R9
  ack_tighten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq) |=> (mask < $past(mask)));

  // R9
  idle_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_irq && $past(rst_n)) |=> $stable(st_mask));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack),
  .mask(mask), .st_mask(st_mask), .en(en)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, cpu_ack = 1'b0;
  logic [63:0] src_in = '0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cpu_irq;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_ack(cpu_ack), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ack();
    @(negedge clk);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(cpu_irq), 0);
    rd(8'h01, d); chk("R1 mask", d, 0);
    rd(8'h85, d); chk("R1 ctrl", d, 32'h07);
    rd(8'h00, d); chk("R10 status", d, 32'hA000_0000);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    wr(8'h01, 7);
    wr(8'h83, 32'h5A);
    src_in[3] = 1'b1;
    step(1);
    rd(8'h83, d); chk("R2 one edge", d, 32'h5A);
    chk("R2 irq early", 32'(cpu_irq), 0);
    step(1);
    rd(8'h83, d); chk("R2 two edges", d, 32'hDA);
    chk("R5 irq on", 32'(cpu_irq), 1);
    src_in[3] = 1'b0;
    step(2);
    chk("R5 irq off", 32'(cpu_irq), 0);
    wr(8'h83, 32'h1A);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(8'h8A, 32'h51);
    src_in[10] = 1'b1; step(4);
    chk("R3 rise", 32'(cpu_irq), 1);
    src_in[10] = 1'b0; step(4);
    rd(8'h8A, d); chk("R4 held", d, 32'hD1);
    wr(8'h8A, 32'hD1);
    chk("R4 set-write keeps", 32'(cpu_irq), 1);
    wr(8'h8A, 32'h51);
    chk("R11 clear drops", 32'(cpu_irq), 0);
    wr(8'h8A, 32'h11);
    wr(8'h8B, 32'h41);
    src_in[11] = 1'b1; step(4);
    chk("R3 fall ignores rise", 32'(cpu_irq), 0);
    src_in[11] = 1'b0; step(4);
    chk("R3 fall", 32'(cpu_irq), 1);
    wr(8'h8B, 32'h01);
    chk("R4 cleared", 32'(cpu_irq), 0);
    wr(8'h8C, 32'h49);
    chk("R3 low level", 32'(cpu_irq), 1);
    src_in[12] = 1'b1; step(3);
    chk("R5 low level gone", 32'(cpu_irq), 0);
    wr(8'h8C, 32'h09);
  endtask

  task automatic t_disable();
    wr(8'h94, 32'h1A);
    src_in[20] = 1'b1; step(3);
    chk("R6 enable off", 32'(cpu_irq), 0);
    wr(8'h94, 32'h5F);
    chk("R6 level 7", 32'(cpu_irq), 0);
    wr(8'h94, 32'h5B);
    chk("R6 enabled", 32'(cpu_irq), 1);
  endtask

  task automatic t_mask();
    wr(8'h01, 3);
    chk("R7 equal level blocked", 32'(cpu_irq), 0);
    wr(8'h01, 4);
    chk("R7 admitted", 32'(cpu_irq), 1);
    wr(8'h01, 0);
    chk("R11 mask drop", 32'(cpu_irq), 0);
    src_in[20] = 1'b0;
    wr(8'h94, 32'h1B);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(8'h01, 7);
    wr(8'h9E, 32'h5A);
    wr(8'h99, 32'h5C);
    wr(8'hA8, 32'h5A);
    src_in[30] = 1'b1; src_in[25] = 1'b1; src_in[40] = 1'b1;
    step(3);
    ack();
    rd(8'h00, d); chk("R8 tie low number", d, 32'hA000_071E);
    rd(8'h01, d); chk("R9 mask raised", d, 2);
    chk("R9 equal blocked", 32'(cpu_irq), 0);
    wr(8'h01, 3);
    wr(8'h9E, 32'h1A);
    ack();
    rd(8'h00, d); chk("R8 next tie", d, 32'hA000_0328);
    wr(8'h01, 7);
    wr(8'hA8, 32'h5D);
    ack();
    rd(8'h00, d); chk("R8 lowest level", d, 32'hA000_0719);
    rd(8'h01, d); chk("R9 mask to 4", d, 4);
  endtask

  task automatic t_idle_ack();
    logic [31:0] d;
    wr(8'h01, 0);
    ack();
    rd(8'h01, d); chk("R9 idle ack mask", d, 0);
    rd(8'h00, d); chk("R9 idle ack status", d, 32'hA000_0719);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_sync();
    t_edge();
    t_disable();
    t_mask();
    t_prio();
    t_idle_ack();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule